// File: doc/BRIEF.md
# Preamble and Sync Word Detector

This block sits behind a demodulator and watches a serial stream of received bits, one bit per cycle in which a bit-valid strobe is high. It first hunts for a run of alternating ones and zeros, the training pattern that opens every frame. Once that run reaches a programmable length, it reports a valid preamble and starts comparing the most recent bits against a programmable sync word of one to four bytes. When the sync word is found it reports that event.

A single output tells the bit clock recovery loop which gain to use. High gain gives fast acquisition while the preamble is being hunted. Low gain gives slow tracking, with less jitter, from the moment the preamble is accepted. If the sync word does not arrive within a window derived from the configured preamble length, the block falls back to hunting, and fast gain is selected again.

Two modes change the fallback behaviour. In skip-sync mode the block parks in sync search with slow gain for as long as it is not reset. In continuous mode, a found sync word locks the block in slow tracking until reset.

Top module: `frame_sync_detector`

## Requirements
- R1: While reset is high and on the first cycle after it, the state output is 0 (hunt), the gain output is 0 (fast), and both event pulses are low.
- R2: In hunt, a preamble-valid pulse of exactly one cycle appears in the cycle after the accepted bit that makes the run of alternating bits reach the threshold. The threshold is 4 × `cfg_det_nib` bits, and a value of 0 is treated as 4 bits.
- R3: A bit equal to its predecessor breaks the run, and counting restarts with that bit as a run of one. The first bit seen after entering hunt always starts a run of one.
- R4: The sync word length is (`cfg_sync_len` + 1) bytes. The first bit on the wire is compared with bit 31 of `cfg_sync_word`, and with fewer than four bytes the upper bytes of `cfg_sync_word` are used. The comparison covers the most recent bits in arrival order.
- R5: In sync search, a match raises a one-cycle sync-ok pulse in the cycle after the last sync bit. Without continuous mode the block then returns to hunt (state 0, fast gain).
- R6: The sync search window is 4 × (`cfg_pre_nib` − `cfg_det_nib`) + 8 × (`cfg_sync_len` + 1) + 8 bits, with the difference taken as 0 if it is negative. The last bit of the window may still match. If it does not match, the block is back in hunt on the next cycle.
- R7: The gain output is 0 (fast) in hunt and 1 (slow) in every other state, and it changes in the same cycle as the state output.
- R8: With `cfg_skip_sync` high, after preamble-valid the block stays in sync search (state 1, slow gain) for any number of bits, and it never pulses sync-ok.
- R9: With `cfg_continuous` high and skip-sync low, a sync-ok moves the block to state 2 with slow gain. It remains there, with no further pulses, for any input until reset.
- R10: Cycles with `bit_valid` low change neither the state nor any run or match progress, and they raise no pulse.
- R11: The state output encoding is 0 = hunt, 1 = sync search, 2 = locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a received bit on `bit_in` |
| bit_in | input | 1 | Demodulated data bit |
| cfg_det_nib | input | 5 | Preamble detection threshold in nibbles |
| cfg_pre_nib | input | 9 | Expected preamble length in nibbles |
| cfg_sync_len | input | 2 | Sync word length minus one, in bytes |
| cfg_sync_word | input | 32 | Sync pattern, first bit in bit 31 |
| cfg_skip_sync | input | 1 | Hold in sync search after preamble, no timeout |
| cfg_continuous | input | 1 | Lock after the first sync-ok until reset |
| pre_valid | output | 1 | One-cycle pulse on preamble acceptance |
| sync_ok | output | 1 | One-cycle pulse on sync word match |
| slow_gain | output | 1 | 0 selects fast acquisition, 1 selects slow tracking |
| state_o | output | 2 | Current state (0 hunt, 1 sync search, 2 locked) |

## Verification
Clean alternating runs check the exact threshold count. A run broken by a repeated bit, and a threshold of zero, tell apart a counter that restarts properly from one that keeps counting or miscounts at the edges. Sync words of one, two and four bytes, sent straight after the preamble, check the byte selection and the bit order. A constant stream after the preamble drives the timeout to its last bit, which pins down the window arithmetic. Skip-sync and continuous runs send valid sync words and further preambles after the decision point, which shows that the hold and the lock really ignore them. Idle gaps are mixed into the stream throughout.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int DET_W       = 5;
    localparam int LEN_W       = 9;
    localparam int RUN_W       = 8;
    localparam int RUN_MAX     = (1 << RUN_W) - 1;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SYNC = 2'd1,
        ST_LOCK = 2'd2
    } fsd_state_e;

    typedef struct packed {
        logic       pre_ev;
        logic       sync_ev;
        fsd_state_e nxt;
    } fsd_decision_t;

    // Threshold in bits; a zero setting means one nibble.
    function automatic logic [RUN_W-1:0] thr_bits(input logic [DET_W-1:0] nib);
        logic [RUN_W-1:0] r;
        if (nib == '0) r = RUN_W'(4);
        else           r = RUN_W'({nib, 2'b00});
        return r;
    endfunction

    // Sync search window in bits.
    function automatic logic [LEN_W+3:0] window_bits(
        input logic [LEN_W-1:0] pre_nib,
        input logic [DET_W-1:0] det_nib,
        input logic [1:0]       len_code,
        input int unsigned      margin
    );
        logic [LEN_W+3:0] gap;
        logic [LEN_W+3:0] sbits;
        if (pre_nib > LEN_W'(det_nib))
            gap = (LEN_W+4)'(pre_nib - LEN_W'(det_nib)) << 2;
        else
            gap = '0;
        sbits = (LEN_W+4)'({len_code, 3'b000}) + (LEN_W+4)'(8);
        return gap + sbits + (LEN_W+4)'(margin);
    endfunction

endpackage

// File: rtl/fsd_alt_run.sv
module fsd_alt_run
    import fsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [RUN_W-1:0] thr,
    output logic             hit
);
    logic             prev_bit;
    logic             have_prev;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    always_comb begin
        if (!have_prev || bit_in == prev_bit)
            run_d = RUN_W'(1);
        else if (run_q == RUN_W'(RUN_MAX))
            run_d = run_q;
        else
            run_d = run_q + RUN_W'(1);
    end

    assign hit = enable && bit_valid && (run_d >= thr);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
            run_q     <= '0;
        end else if (bit_valid) begin
            prev_bit  <= bit_in;
            have_prev <= 1'b1;
            run_q     <= run_d;
        end
    end

    // R3: a run never grows by more than one per accepted bit
    a_r3_run_step: assert property (@(posedge clk) disable iff (rst)
        (enable && bit_valid && have_prev && run_q != RUN_W'(RUN_MAX)) |=>
            (run_q <= $past(run_q) + RUN_W'(1)));

endmodule

// File: rtl/fsd_sync_match.sv
module fsd_sync_match #(
    parameter int SYNC_BYTES = 4,
    parameter int CODE_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    input  logic [CODE_W-1:0]       len_code,
    input  logic [8*SYNC_BYTES-1:0] word,
    output logic                    match
);
    localparam int SYNC_BITS = 8 * SYNC_BYTES;

    logic [SYNC_BITS-1:0]  hist_q;
    logic [SYNC_BITS-1:0]  hist_d;
    logic [SYNC_BYTES-1:0] len_hit;

    assign hist_d = {hist_q[SYNC_BITS-2:0], bit_in};

    for (genvar g = 0; g < SYNC_BYTES; g++) begin : g_len
        localparam int NB = 8 * (g + 1);
        assign len_hit[g] = (hist_d[NB-1:0] == word[SYNC_BITS-1 -: NB]);
    end

    assign match = bit_valid && len_hit[len_code];

    always_ff @(posedge clk) begin
        if (rst)            hist_q <= '0;
        else if (bit_valid) hist_q <= hist_d;
    end

    // R10: history only moves on accepted bits
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(hist_q));

endmodule

// File: rtl/fsd_window_timer.sv
module fsd_window_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + W'(1);
    assign expire  = step && (cnt_inc >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_inc;
    end

    // R6: count restarts from zero when the window is closed
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
    import fsd_pkg::*;
#(
    parameter int SYNC_BYTES  = 4,
    parameter int MARGIN_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_valid,
    input  logic                        bit_in,
    input  logic [DET_W-1:0]            cfg_det_nib,
    input  logic [LEN_W-1:0]            cfg_pre_nib,
    input  logic [$clog2(SYNC_BYTES)-1:0] cfg_sync_len,
    input  logic [8*SYNC_BYTES-1:0]     cfg_sync_word,
    input  logic                        cfg_skip_sync,
    input  logic                        cfg_continuous,
    output logic                        pre_valid,
    output logic                        sync_ok,
    output logic                        slow_gain,
    output logic [1:0]                  state_o
);
    localparam int CODE_W = $clog2(SYNC_BYTES);
    localparam int WIN_W  = LEN_W + 4;

    fsd_state_e    state_q;
    fsd_decision_t dec;
    logic          run_hit;
    logic          sync_match;
    logic          win_expire;
    logic          win_step;
    logic [WIN_W-1:0] win_limit;

    assign win_limit = window_bits(cfg_pre_nib, cfg_det_nib, 2'(cfg_sync_len), MARGIN_BITS);
    assign win_step  = bit_valid && (state_q == ST_SYNC) && !cfg_skip_sync;

    fsd_alt_run u_run (
        .clk       (clk),
        .rst       (rst),
        .enable    (state_q == ST_HUNT),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .thr       (thr_bits(cfg_det_nib)),
        .hit       (run_hit)
    );

    fsd_sync_match #(.SYNC_BYTES(SYNC_BYTES), .CODE_W(CODE_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .len_code  (cfg_sync_len),
        .word      (cfg_sync_word),
        .match     (sync_match)
    );

    fsd_window_timer #(.W(WIN_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .clear  (state_q != ST_SYNC),
        .step   (win_step),
        .limit  (win_limit),
        .expire (win_expire)
    );

    always_comb begin
        dec.pre_ev  = 1'b0;
        dec.sync_ev = 1'b0;
        dec.nxt     = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (run_hit) begin
                    dec.pre_ev = 1'b1;
                    dec.nxt    = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (!cfg_skip_sync && bit_valid) begin
                    if (sync_match) begin
                        dec.sync_ev = 1'b1;
                        dec.nxt     = cfg_continuous ? ST_LOCK : ST_HUNT;
                    end else if (win_expire) begin
                        dec.nxt = ST_HUNT;
                    end
                end
            end
            default: dec.nxt = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HUNT;
            pre_valid <= 1'b0;
            sync_ok   <= 1'b0;
            slow_gain <= 1'b0;
        end else begin
            state_q   <= dec.nxt;
            pre_valid <= dec.pre_ev;
            sync_ok   <= dec.sync_ev;
            slow_gain <= (dec.nxt != ST_HUNT);
        end
    end

    assign state_o = state_q;

    a_r2_pre_single: assert property (@(posedge clk) disable iff (rst)
        pre_valid |=> !pre_valid);

    a_r5_sync_single: assert property (@(posedge clk) disable iff (rst)
        sync_ok |=> !sync_ok);

    a_r7_gain_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_gain) |-> pre_valid);

    a_r8_skip_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SYNC && cfg_skip_sync) |=> (state_o == 2'd1 && !sync_ok));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK) |=> (state_o == 2'd2 && slow_gain && !pre_valid && !sync_ok));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(state_o) && !pre_valid && !sync_ok));

    a_r11_state_legal: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd3);

endmodule

// File: tb/test_frame_sync_detector.sv
module test_frame_sync_detector;

    typedef struct {
        logic [1:0] st;
        logic       slow;
        logic       pv;
        logic       so;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [4:0]  cfg_det_nib = 5'd3;
    logic [8:0]  cfg_pre_nib = 9'd4;
    logic [1:0]  cfg_sync_len = 2'd1;
    logic [31:0] cfg_sync_word = 32'h2DD4_0000;
    logic        cfg_skip_sync = 1'b0;
    logic        cfg_continuous = 1'b0;
    logic        pre_valid, sync_ok, slow_gain;
    logic [1:0]  state_o;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";
    exp_t q[$];

    // bench model state
    int          m_st = 0;
    bit          m_have = 0;
    bit          m_prev = 0;
    int          m_run = 0;
    int          m_cnt = 0;
    logic [31:0] m_hist = '0;

    always #5 clk = ~clk;

    frame_sync_detector i_frame_sync_detector (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .cfg_det_nib(cfg_det_nib), .cfg_pre_nib(cfg_pre_nib),
        .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word),
        .cfg_skip_sync(cfg_skip_sync), .cfg_continuous(cfg_continuous),
        .pre_valid(pre_valid), .sync_ok(sync_ok), .slow_gain(slow_gain),
        .state_o(state_o)
    );

    function automatic int thr_of();
        return (cfg_det_nib == 0) ? 4 : 4 * int'(cfg_det_nib);
    endfunction

    function automatic int win_of();
        int d = int'(cfg_pre_nib) - int'(cfg_det_nib);
        if (d < 0) d = 0;
        return 4 * d + 8 * (int'(cfg_sync_len) + 1) + 8;
    endfunction

    function automatic bit sync_seen();
        int n = 8 * (int'(cfg_sync_len) + 1);
        for (int i = 0; i < n; i++)
            if (m_hist[i] !== cfg_sync_word[32 - n + i]) return 1'b0;
        return 1'b1;
    endfunction

    // driver: one cycle of stimulus, expectation pushed to the scoreboard
    task automatic step(input bit v, input bit b);
        exp_t e;
        @(negedge clk);
        bit_valid = v;
        bit_in    = b;
        e.pv = 1'b0;
        e.so = 1'b0;
        if (v) begin
            m_hist = {m_hist[30:0], b};
            if (m_st == 0) begin
                if (!m_have || b == m_prev) m_run = 1;
                else if (m_run < 255)       m_run = m_run + 1;
                m_have = 1; m_prev = b;
                if (m_run >= thr_of()) begin
                    m_st = 1; e.pv = 1'b1; m_cnt = 0; m_have = 0; m_run = 0;
                end
            end else if (m_st == 1 && !cfg_skip_sync) begin
                if (sync_seen()) begin
                    e.so = 1'b1;
                    m_st = cfg_continuous ? 2 : 0;
                end else if (m_cnt + 1 >= win_of()) begin
                    m_st = 0;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
        e.st   = 2'(m_st);
        e.slow = (m_st != 0);
        e.req  = cur_req;
        q.push_back(e);
    endtask

    task automatic send_alt(input int n, input bit first);
        for (int i = 0; i < n; i++) step(1'b1, first ^ i[0]);
    endtask

    task automatic send_const(input int n, input bit b);
        for (int i = 0; i < n; i++) step(1'b1, b);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 31; i > 31 - n; i--) begin
            step(1'b1, w[i]);
            if (i % 5 == 0) step(1'b0, 1'b0);   // R10: idle gaps inside the stream
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0;
        repeat (2) @(negedge clk);
        n_vec++;
        if (state_o !== 2'd0 || slow_gain !== 1'b0 || pre_valid !== 1'b0 || sync_ok !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: st=%0d slow=%0b pv=%0b so=%0b expected 0 0 0 0",
                     state_o, slow_gain, pre_valid, sync_ok);
        end
        rst = 1'b0;
        m_st = 0; m_have = 0; m_run = 0; m_cnt = 0; m_hist = '0;
    endtask

    // monitor: pops one expectation per stimulus cycle, compares after the edge
    // (R7 gain and R11 state encoding are compared on every vector)
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            #2;
            e = q.pop_front();
            n_vec++;
            if (state_o !== e.st || slow_gain !== e.slow || pre_valid !== e.pv || sync_ok !== e.so) begin
                n_bad++;
                $display("FAIL %s: st=%0d slow=%0b pv=%0b so=%0b expected st=%0d slow=%0b pv=%0b so=%0b",
                         e.req, state_o, slow_gain, pre_valid, sync_ok, e.st, e.slow, e.pv, e.so);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        cur_req = "R1"; step(1'b0, 1'b0);

        // R2: 12-bit threshold, then 2-byte sync, R5 return to hunt
        cur_req = "R2"; send_alt(12, 1'b1);
        cur_req = "R5"; send_bits(32'h2DD4_0000, 16);
        cur_req = "R7"; step(1'b0, 1'b0);

        // R3: run broken by a repeated bit, then restarted
        cur_req = "R3"; send_alt(7, 1'b0); step(1'b1, 1'b0); send_alt(11, 1'b1);
        cur_req = "R3"; send_alt(3, 1'b1);

        // R6: window expiry on constant zeros (window = 4*1 + 16 + 8 = 28)
        cur_req = "R6"; send_const(30, 1'b0);
        cur_req = "R6"; send_alt(12, 1'b0);
        cur_req = "R6"; send_const(27, 1'b0); send_bits(32'h2DD4_0000, 16);

        // R4: 4-byte word, threshold code zero (4 bits)
        do_reset();
        cfg_det_nib = 5'd0; cfg_pre_nib = 9'd2; cfg_sync_len = 2'd3; cfg_sync_word = 32'h1ACF_FC1D;
        cur_req = "R4"; send_alt(4, 1'b1); send_bits(32'h1ACF_FC1D, 32);
        // R4: 1-byte word
        cfg_sync_len = 2'd0; cfg_sync_word = 32'hA700_0000;
        cur_req = "R4"; send_alt(6, 1'b1); send_const(2, 1'b1); send_bits(32'hA700_0000, 8);

        // R8: skip-sync hold
        do_reset();
        cfg_det_nib = 5'd3; cfg_pre_nib = 9'd4; cfg_sync_len = 2'd1; cfg_sync_word = 32'h2DD4_0000;
        cfg_skip_sync = 1'b1;
        cur_req = "R8"; send_alt(12, 1'b0); send_const(40, 1'b1);
        send_bits(32'h2DD4_0000, 16); send_alt(20, 1'b0);
        cfg_skip_sync = 1'b0;

        // R9: continuous lock
        do_reset();
        cfg_continuous = 1'b1;
        cur_req = "R9"; send_alt(12, 1'b1); send_bits(32'h2DD4_0000, 16);
        send_alt(24, 1'b0); send_bits(32'h2DD4_0000, 16); send_const(40, 1'b0);
        cur_req = "R10"; repeat (4) step(1'b0, 1'b1);
        do_reset();
        cfg_continuous = 1'b0;
        cur_req = "R10"; send_alt(6, 1'b1); repeat (5) step(1'b0, 1'b1); send_alt(6, 1'b0);

        @(negedge clk); bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule